// File: doc/BRIEF.md
# Reduced-Rate Raster Scan Timing Generator

This block produces the horizontal and vertical synchronisation strobes, a display-enable flag and the current beam coordinates for a 640x480, roughly 60 Hz raster. It runs from one system clock qualified by a pixel-rate enable. Each line holds 264 horizontal counts rather than the usual 800, so every count covers about three standard pixel times. The line period and the frame period still match the standard mode. A pixel source downstream uses the coordinates to fetch colour data and uses display-enable to blank it.

Two synchronous wrap counters run on the same clock. The horizontal counter advances once per enabled cycle. Its wrap steps the vertical counter. Sync, enable and coordinate outputs are all registered on the same edge, so they never skew against each other. Every region boundary is a parameter, and the defaults give the reduced-rate timing.

Top module: `scan_timing_gen`

## Requirements
- R1: `x_o` advances by one on every clock edge where `pix_en_i` is high, counts 0 to 263, and returns from 263 to 0.
- R2: `y_o` advances by one only on the enabled edge where `x_o` returns from 263 to 0. It counts 0 to 524 and returns from 524 to 0 at the end of the frame.
- R3: `hsync_o` is low (active) exactly while `x_o` is in 210..241 and is high for all other horizontal counts.
- R4: `vsync_o` is low (active) exactly while `y_o` is in 490..491 and is high for all other line counts.
- R5: `de_o` is high exactly when `x_o` < 200 and `y_o` < 480.
- R6: Sync, display-enable and coordinate outputs are registers updated on the same edge. Each output always matches the `x_o`/`y_o` values it is presented with, with no lag between them.
- R7: While `pix_en_i` is low, every output holds its value.
- R8: While `rst_ni` is low, and after reset is released, `x_o` = 0, `y_o` = 0, `hsync_o` = 1, `vsync_o` = 1 and `de_o` = 1. This holds even when reset arrives in the middle of a sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-rate enable; one count per high cycle |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Display enable, high in the visible area |
| x_o | output | 9 | Horizontal count 0..263 |
| y_o | output | 10 | Line count 0..524 |

## Verification
Every output reflects the enabled edge itself: after N enabled edges since reset, all five outputs already show the state of count N. There is no extra pipeline stage between the coordinates and the strobes. The bench therefore raises the enable at a falling edge, lets exactly N rising edges pass, drops it at the next falling edge and compares all outputs there. The expected values come from the count N alone. Enable-low holds and asynchronous reset take effect without waiting for a clock edge, so those checks sample at the falling edge that follows.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // true when lo <= v < hi
  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v < hi);
  endfunction
endpackage

// File: rtl/scan_axis_cnt.sv
module scan_axis_cnt #(
  parameter int unsigned LEN = 264,
  localparam int unsigned W = $clog2(LEN)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  always_comb begin
    last   = (cnt_q == W'(LEN - 1));
    wrap_o = step_i && last;
    if (!step_i)   nxt_o = cnt_q;
    else if (last) nxt_o = '0;
    else           nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;

  assign cnt_o = cnt_q;

  assert_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < LEN);
endmodule

// File: rtl/scan_phase.sv
module scan_phase #(
  parameter int unsigned W        = 9,
  parameter int unsigned VIS      = 200,
  parameter int unsigned SYNC_BEG = 210,
  parameter int unsigned SYNC_END = 242
) (
  input  logic [W-1:0] pos_i,
  output logic         vis_o,
  output logic         sync_n_o
);
  import scan_pkg::*;
  assign vis_o    = 32'(pos_i) < VIS;
  assign sync_n_o = !in_span(32'(pos_i), SYNC_BEG, SYNC_END);
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int unsigned H_VIS  = 200,
  parameter int unsigned H_FP   = 10,
  parameter int unsigned H_SYNC = 32,
  parameter int unsigned H_BP   = 22,
  parameter int unsigned V_VIS  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33,
  localparam int unsigned H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int unsigned XW    = $clog2(H_TOT),
  localparam int unsigned YW    = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  logic [XW-1:0] x_nxt;
  logic [YW-1:0] y_nxt;
  logic          line_end, frame_end;
  logic          h_vis, v_vis, h_sn, v_sn;
  logic          hsync_q, vsync_q, de_q;

  scan_axis_cnt #(.LEN(H_TOT)) u_hcnt (
    .clk_i, .rst_ni, .step_i(pix_en_i),
    .cnt_o(x_o), .nxt_o(x_nxt), .wrap_o(line_end)
  );

  scan_axis_cnt #(.LEN(V_TOT)) u_vcnt (
    .clk_i, .rst_ni, .step_i(line_end),
    .cnt_o(y_o), .nxt_o(y_nxt), .wrap_o(frame_end)
  );

  // decode the next counts so strobes land on the same edge as the coordinates
  scan_phase #(.W(XW), .VIS(H_VIS), .SYNC_BEG(H_VIS + H_FP),
               .SYNC_END(H_VIS + H_FP + H_SYNC)) u_hdec (
    .pos_i(x_nxt), .vis_o(h_vis), .sync_n_o(h_sn)
  );

  scan_phase #(.W(YW), .VIS(V_VIS), .SYNC_BEG(V_VIS + V_FP),
               .SYNC_END(V_VIS + V_FP + V_SYNC)) u_vdec (
    .pos_i(y_nxt), .vis_o(v_vis), .sync_n_o(v_sn)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hsync_q <= 1'b1;
      vsync_q <= 1'b1;
      de_q    <= 1'b1;
    end else begin
      hsync_q <= h_sn;
      vsync_q <= v_sn;
      de_q    <= h_vis && v_vis;
    end

  assign hsync_o = hsync_q;
  assign vsync_o = vsync_q;
  assign de_o    = de_q;

  assert_hwrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && 32'(x_o) == H_TOT - 1) |=> x_o == '0);
  assert_vstep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && 32'(x_o) == H_TOT - 1 && 32'(y_o) != V_TOT - 1)
      |=> y_o == $past(y_o) + 1'b1);
  assert_vhold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pix_en_i && 32'(x_o) == H_TOT - 1) |=> $stable(y_o));
  assert_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> y_o == '0);
  assert_hsync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> (32'(x_o) >= H_VIS + H_FP && 32'(x_o) < H_VIS + H_FP + H_SYNC));
  assert_vsync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> (32'(y_o) >= V_VIS + V_FP && 32'(y_o) < V_VIS + V_FP + V_SYNC));
  assert_de_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (32'(x_o) < H_VIS && 32'(y_o) < V_VIS));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> ($stable(x_o) && $stable(hsync_o) && $stable(vsync_o) && $stable(de_o)));
endmodule

// File: tb/scan_timing_gen_test.sv
module scan_timing_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       hs, vs, de;
  logic [8:0] x;
  logic [9:0] y;
  int n_chk = 0;
  int n_bad = 0;
  int pos = 0;

  always #4 clk = ~clk;

  scan_timing_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(en),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .x_o(x), .y_o(y)
  );

  localparam int NV = 16;
  localparam int K_TAB [NV] = '{0, 199, 200, 209, 210, 241, 242, 263, 264,
                                126655, 126720, 129359, 129360, 129839, 129888, 138599};

  task automatic chk(input string req, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s at count %0d: got %0d expected %0d", req, what, pos, got, exp);
    end
  endtask

  // expected outputs derived from enable count k since reset
  task automatic check_at(input int k);
    int ex = k % 264;
    int ey = (k / 264) % 525;
    chk("R1", int'(x), ex, "x");
    chk("R2", int'(y), ey, "y");
    chk("R3", int'(hs), (ex >= 210 && ex < 242) ? 0 : 1, "hsync");
    chk("R4", int'(vs), (ey >= 490 && ey < 492) ? 0 : 1, "vsync");
    chk("R5", int'(de), (ex < 200 && ey < 480) ? 1 : 0, "de");
  endtask

  task automatic step(input int n);
    if (n > 0) begin
      en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      en = 1'b0;
      pos += n;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at count %0d", pos);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8: state held in reset
    repeat (3) @(negedge clk);
    check_at(0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table walk: R1..R6 at region boundaries (R6: all outputs agree each sample)
    for (int i = 0; i < NV; i++) begin
      step(K_TAB[i] - pos);
      check_at(pos);
    end

    // R2: frame wrap 524 -> 0
    step(1);
    check_at(pos);
    chk("R2", int'(y), 0, "y after frame wrap");

    // R7: enable low holds everything
    step(215);
    repeat (20) @(negedge clk);
    check_at(pos);

    // R1/R6: sparse enable pattern, one count per high cycle only
    for (int i = 0; i < 12; i++) begin
      step(1);
      @(negedge clk);
    end
    check_at(pos);

    // R8: reset in the middle of hsync
    step(234 - (pos % 264));
    chk("R3", int'(hs), 0, "hsync before reset");
    rst_n = 1'b0;
    #1;
    chk("R8", int'(x), 0, "x in reset");
    chk("R8", int'(hs), 1, "hsync in reset");
    @(negedge clk);
    pos = 0;
    check_at(0);
    rst_n = 1'b1;
    @(negedge clk);
    check_at(0);
    step(230);
    check_at(pos);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule